// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the input divider, loop multiplier and output divider of a clock synthesiser so that the synthesised frequency lands as close as possible to a requested target. A start pulse captures a reference frequency, a target frequency and a pair of lane rate limits. The engine then walks the candidate dividers in a fixed order. For each candidate pair it derives the multiplier by rounding, checks the multiplier against a VCO window, computes the resulting frequency, and keeps the candidate with the smallest error.

The search stops on its own in three ways. It stops as soon as a candidate hits the target exactly. It stops when the VCO window for the current input divider can no longer admit any multiplier. Otherwise it stops after the last candidate. Every division goes through one shared iterative divider that produces one quotient bit per clock. Results, a one-cycle done pulse, and flags for rejected inputs and for "nothing fits" are presented together.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `done`, `bad_input` and `no_fit` are 0, and `idf`, `ndiv`, `odf` and `fout_khz` are 0.
- R2: When a solution is reported, `idf` is in 1..7, `ndiv` is in 10..125, and `odf` carries the plain binary value 1, 2, 4 or 8.
- R3: The reported `fout_khz` equals floor((clkin × ndiv + floor(idf×odf/2)) / (idf × odf)), which is the rounded quotient.
- R4: Candidates are visited with the input divider ascending from 1 and, within it, the output divider ascending through 1, 2, 4, 8. The candidate multiplier is round(idf × odf × target / clkin). A candidate replaces the kept one only when its absolute error is strictly smaller.
- R5: The VCO lower limit is lane_lo × 16 and the upper limit is lane_hi × 2. For input divider i, a multiplier is admissible only in [max(10, floor(vco_lo×i/(2×clkin))+1), min(125, floor(vco_hi×i/(2×clkin)))].
- R6: If floor(vco_lo×i/(2×clkin))+1 is 125 or more for the current input divider, the search ends without visiting larger input dividers. With i=1 this gives done after no more than three divider runs.
- R7: A candidate with zero error ends the search at once. When the very first candidate is exact, done follows after four divider runs.
- R8: A reference or target that is zero, or that has its top bit set (a negative value), is rejected. `done` rises with `bad_input`=1 and all results 0.
- R9: If no candidate is accepted, `done` rises with `no_fit`=1 and `idf`, `ndiv`, `odf` and `fout_khz` all 0.
- R10: With `rev_fast`=1, both lane limits are doubled before the VCO window is formed.
- R11: `done` is high for exactly one cycle per accepted start. A start that arrives while a search is running is ignored, and its inputs do not affect the result.
- R12: The kept error starts at 1,000,000 kHz. A candidate whose error is 1,000,000 or more is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when idle |
| rev_fast | input | 1 | Doubles both lane limits |
| clkin_khz | input | FW | Reference frequency, kHz |
| clkout_khz | input | FW | Target frequency, kHz |
| lane_lo_kbps | input | FW | Lane minimum rate, kbps |
| lane_hi_kbps | input | FW | Lane maximum rate, kbps |
| done | output | 1 | One-cycle result strobe |
| bad_input | output | 1 | Inputs rejected |
| no_fit | output | 1 | No candidate accepted |
| idf | output | 3 | Chosen input divider |
| ndiv | output | 7 | Chosen loop multiplier |
| odf | output | 4 | Chosen output divider value |
| fout_khz | output | FW | Frequency of the chosen triple, kHz |

## Verification
The bench builds the engine with FW=32 and PW=48. The 48-bit product width lets it drive lane limits in the tens of millions of kbps and references in the millions of kHz without overflow. That range is what reaches the case where a window-admissible candidate still misses by more than the 1,000,000 kHz starting error. The same widths make a divider run last 51 cycles. This gives the early-exit and window-break paths a latency that is clearly shorter than a full search, so the bench can check those two paths by counting cycles.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int IDF_MIN   = 1;
  localparam int IDF_MAX   = 7;
  localparam int NDIV_MIN  = 10;
  localparam int NDIV_MAX  = 125;
  localparam int ODF_STEPS = 4;              // 1, 2, 4, 8
  localparam int ODF_MAX   = 1 << (ODF_STEPS - 1);
  localparam int ERR_START = 1000000;        // kHz
  localparam int VCO_LO_MUL = 2 * ODF_MAX;   // applied to lane minimum
  localparam int VCO_HI_MUL = 2;             // applied to lane maximum

  localparam int IW = $clog2(IDF_MAX + 1);
  localparam int NW = $clog2(NDIV_MAX + 1);
  localparam int OW = $clog2(ODF_MAX + 1);
  localparam int KW = $clog2(ODF_STEPS);

  typedef enum logic [3:0] {
    ST_IDLE, ST_NLO, ST_NHI, ST_ICHK, ST_NCAND, ST_FOUT, ST_CMP, ST_STEP, ST_END
  } srch_st_e;

  function automatic logic [63:0] abs_diff(input logic [63:0] a, input logic [63:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [NW-1:0] clamp_lo(input logic [63:0] v);
    return (v < 64'(NDIV_MIN)) ? NW'(NDIV_MIN) : v[NW-1:0];
  endfunction

  function automatic logic [NW-1:0] clamp_hi(input logic [63:0] v);
    return (v > 64'(NDIV_MAX)) ? NW'(NDIV_MAX) : v[NW-1:0];
  endfunction

  function automatic logic [OW-1:0] odf_of(input logic [KW-1:0] k);
    return OW'(1) << k;
  endfunction

endpackage

// File: rtl/pll_vco_window.sv
module pll_vco_window
  import pll_search_pkg::*;
#(
  parameter int FW = 32,
  parameter int PW = 48
) (
  input  logic          rev_fast,
  input  logic [FW-1:0] lane_lo,
  input  logic [FW-1:0] lane_hi,
  output logic [PW-1:0] vco_lo,
  output logic [PW-1:0] vco_hi
);
  localparam int EW = FW + 1;

  logic [EW-1:0] lo_eff, hi_eff;

  always_comb begin
    lo_eff = rev_fast ? {lane_lo, 1'b0} : {1'b0, lane_lo};
    hi_eff = rev_fast ? {lane_hi, 1'b0} : {1'b0, lane_hi};
    vco_lo = PW'(lo_eff) * PW'(VCO_LO_MUL);
    vco_hi = PW'(hi_eff) * PW'(VCO_HI_MUL);
  end
endmodule

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         rnd,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo
);
  localparam int AW = W + 1;
  localparam int CW = $clog2(AW + 1);

  logic [AW-1:0] acc;        // dividend shifts out, quotient shifts in
  logic [W-1:0]  rem;
  logic [CW-1:0] cnt;
  logic [W:0]    rem_sh;
  logic          take;
  logic [W-1:0]  rem_sub;
  logic [AW-1:0] dvd_load;

  always_comb begin
    rem_sh   = {rem, acc[AW-1]};
    take     = rem_sh >= {1'b0, den};
    rem_sub  = rem_sh[W-1:0] - den;
    dvd_load = {1'b0, num} + (rnd ? {2'b00, den[W-1:1]} : {AW{1'b0}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      rem  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        rem <= '0;
        if (den == '0) begin
          acc <= '0;
          fin <= 1'b1;
        end else begin
          acc  <= dvd_load;
          cnt  <= CW'(AW);
          busy <= 1'b1;
        end
      end else if (busy) begin
        acc <= {acc[AW-2:0], take};
        rem <= take ? rem_sub : rem_sh[W-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quo = acc[W-1:0];

  AST_DIV_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n) go |-> !busy); // R3
  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (rem < den)); // R3
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep
  import pll_search_pkg::*;
#(
  parameter int FW = 32,
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cand_vld,
  input  logic [IW-1:0] cand_idf,
  input  logic [NW-1:0] cand_ndiv,
  input  logic [OW-1:0] cand_odf,
  input  logic [PW-1:0] cand_fout,
  input  logic [PW-1:0] target,
  output logic [IW-1:0] best_idf,
  output logic [NW-1:0] best_ndiv,
  output logic [OW-1:0] best_odf,
  output logic [FW-1:0] best_fout,
  output logic          found,
  output logic          cand_better,
  output logic          cand_exact
);
  logic [PW-1:0] best_err;
  logic [PW-1:0] delta;

  always_comb begin
    delta       = PW'(abs_diff(64'(cand_fout), 64'(target)));
    cand_better = cand_vld && (delta < best_err);
    cand_exact  = cand_vld && (delta == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err  <= PW'(ERR_START);
      best_idf  <= '0;
      best_ndiv <= '0;
      best_odf  <= '0;
      best_fout <= '0;
      found     <= 1'b0;
    end else if (clr) begin
      best_err  <= PW'(ERR_START);
      best_idf  <= '0;
      best_ndiv <= '0;
      best_odf  <= '0;
      best_fout <= '0;
      found     <= 1'b0;
    end else if (cand_better) begin
      best_err  <= delta;
      best_idf  <= cand_idf;
      best_ndiv <= cand_ndiv;
      best_odf  <= cand_odf;
      best_fout <= cand_fout[FW-1:0];
      found     <= 1'b1;
    end
  end

  AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) !clr |=> (best_err <= $past(best_err))); // R4
  AST_FOUND_BELOW_START: assert property (@(posedge clk) disable iff (!rst_n) found |-> (best_err < PW'(ERR_START))); // R12
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int FW = 32,
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rev_fast,
  input  logic [FW-1:0] clkin_khz,
  input  logic [FW-1:0] clkout_khz,
  input  logic [FW-1:0] lane_lo_kbps,
  input  logic [FW-1:0] lane_hi_kbps,
  output logic          done,
  output logic          bad_input,
  output logic          no_fit,
  output logic [IW-1:0] idf,
  output logic [NW-1:0] ndiv,
  output logic [OW-1:0] odf,
  output logic [FW-1:0] fout_khz
);
  srch_st_e st;

  logic [FW-1:0] cin, cout;
  logic [PW-1:0] vmin, vmax, vco_lo_w, vco_hi_w;
  logic [IW-1:0] idx_i;
  logic [KW-1:0] idx_o;
  logic [PW-1:0] nmin_raw, nmax_raw, fcand;
  logic [NW-1:0] nlo, nhi, ncand;
  logic          pend, inv_r;

  // divider interface
  logic          div_go, div_rnd, div_busy, div_fin;
  logic [PW-1:0] div_num, div_den, div_quo;
  logic [PW-1:0] io_prod;

  // best tracker interface
  logic          best_clr, cand_vld, found, cand_better, cand_exact;
  logic [IW-1:0] b_idf;
  logic [NW-1:0] b_ndiv;
  logic [OW-1:0] b_odf;
  logic [FW-1:0] b_fout;

  // named internal events
  logic in_bad, ev_break, ev_skip, ev_accept, ev_exact;

  assign in_bad   = (clkin_khz == '0) || clkin_khz[FW-1] || (clkout_khz == '0) || clkout_khz[FW-1];
  assign ev_break = (st == ST_ICHK) && (nmin_raw >= PW'(NDIV_MAX));
  assign ev_skip  = (st == ST_NCAND) && div_fin &&
                    ((div_quo < PW'(nlo)) || (div_quo > PW'(nhi)));
  assign ev_accept = cand_better;
  assign ev_exact  = cand_exact;
  assign best_clr  = (st == ST_IDLE) && start;
  assign cand_vld  = (st == ST_CMP);
  assign io_prod   = PW'(idx_i) << idx_o;

  pll_vco_window #(.FW(FW), .PW(PW)) u_win (
    .rev_fast (rev_fast),
    .lane_lo  (lane_lo_kbps),
    .lane_hi  (lane_hi_kbps),
    .vco_lo   (vco_lo_w),
    .vco_hi   (vco_hi_w)
  );

  always_comb begin
    div_num = '0;
    div_den = '0;
    div_rnd = 1'b0;
    case (st)
      ST_NLO: begin
        div_num = vmin * PW'(idx_i);
        div_den = PW'(cin) << 1;
      end
      ST_NHI: begin
        div_num = vmax * PW'(idx_i);
        div_den = PW'(cin) << 1;
      end
      ST_NCAND: begin
        div_num = PW'(cout) * io_prod;
        div_den = PW'(cin);
        div_rnd = 1'b1;
      end
      ST_FOUT: begin
        div_num = PW'(cin) * PW'(ncand);
        div_den = io_prod;
        div_rnd = 1'b1;
      end
      default: ;
    endcase
    div_go = ((st == ST_NLO) || (st == ST_NHI) || (st == ST_NCAND) || (st == ST_FOUT))
             && !pend && !div_busy;
  end

  pll_rdiv #(.W(PW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .rnd  (div_rnd),
    .num  (div_num),
    .den  (div_den),
    .busy (div_busy),
    .fin  (div_fin),
    .quo  (div_quo)
  );

  pll_best_keep #(.FW(FW), .PW(PW)) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (best_clr),
    .cand_vld   (cand_vld),
    .cand_idf   (idx_i),
    .cand_ndiv  (ncand),
    .cand_odf   (odf_of(idx_o)),
    .cand_fout  (fcand),
    .target     (PW'(cout)),
    .best_idf   (b_idf),
    .best_ndiv  (b_ndiv),
    .best_odf   (b_odf),
    .best_fout  (b_fout),
    .found      (found),
    .cand_better(cand_better),
    .cand_exact (cand_exact)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (div_go) begin
      pend <= 1'b1;
    end else if (div_fin) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cin       <= '0;
      cout      <= '0;
      vmin      <= '0;
      vmax      <= '0;
      idx_i     <= '0;
      idx_o     <= '0;
      nmin_raw  <= '0;
      nmax_raw  <= '0;
      nlo       <= '0;
      nhi       <= '0;
      ncand     <= '0;
      fcand     <= '0;
      inv_r     <= 1'b0;
      done      <= 1'b0;
      bad_input <= 1'b0;
      no_fit    <= 1'b0;
      idf       <= '0;
      ndiv      <= '0;
      odf       <= '0;
      fout_khz  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cin   <= clkin_khz;
          cout  <= clkout_khz;
          vmin  <= vco_lo_w;
          vmax  <= vco_hi_w;
          inv_r <= in_bad;
          idx_i <= IW'(IDF_MIN);
          idx_o <= '0;
          st    <= in_bad ? ST_END : ST_NLO;
        end
        ST_NLO: if (div_fin) begin
          nmin_raw <= div_quo + PW'(1);
          st       <= ST_NHI;
        end
        ST_NHI: if (div_fin) begin
          nmax_raw <= div_quo;
          st       <= ST_ICHK;
        end
        ST_ICHK: begin
          if (ev_break) begin
            st <= ST_END;
          end else begin
            nlo   <= clamp_lo(64'(nmin_raw));
            nhi   <= clamp_hi(64'(nmax_raw));
            idx_o <= '0;
            st    <= ST_NCAND;
          end
        end
        ST_NCAND: if (div_fin) begin
          if (ev_skip) begin
            st <= ST_STEP;
          end else begin
            ncand <= div_quo[NW-1:0];
            st    <= ST_FOUT;
          end
        end
        ST_FOUT: if (div_fin) begin
          fcand <= div_quo;
          st    <= ST_CMP;
        end
        ST_CMP: st <= ev_exact ? ST_END : ST_STEP;
        ST_STEP: begin
          if (idx_o == KW'(ODF_STEPS - 1)) begin
            if (idx_i == IW'(IDF_MAX)) begin
              st <= ST_END;
            end else begin
              idx_i <= idx_i + 1'b1;
              st    <= ST_NLO;
            end
          end else begin
            idx_o <= idx_o + 1'b1;
            st    <= ST_NCAND;
          end
        end
        ST_END: begin
          done      <= 1'b1;
          bad_input <= inv_r;
          no_fit    <= !inv_r && !found;
          idf       <= b_idf;
          ndiv      <= b_ndiv;
          odf       <= b_odf;
          fout_khz  <= b_fout;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (done && !no_fit && !bad_input) |-> ((idf >= IW'(IDF_MIN)) && (idf <= IW'(IDF_MAX)) && (ndiv >= NW'(NDIV_MIN)) && (ndiv <= NW'(NDIV_MAX)) && ($countones(odf) == 1))); // R2
  AST_ZERO_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (done && (no_fit || bad_input)) |-> ((idf == '0) && (ndiv == '0) && (odf == '0) && (fout_khz == '0))); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bad_input && no_fit)); // R8
  AST_NDIV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) ev_accept |-> ((ncand >= nlo) && (ncand <= nhi))); // R5
  AST_BREAK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_NCAND) |-> (nmin_raw < PW'(NDIV_MAX))); // R6
  AST_EXACT_STOP: assert property (@(posedge clk) disable iff (!rst_n) ev_exact |=> (st == ST_END)); // R7
endmodule

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
  localparam int FW = 32;
  localparam int PW = 48;
  localparam int NV = 12;
  localparam int RUN = PW + 5;   // generous cycles per divider run

  // stimulus table: reference, target, lane lo, lane hi, revision, class (0 fit, 1 none, 2 bad)
  localparam bit [31:0] V_CIN [NV] = '{32'd25000, 32'd24000, 32'd8000, 32'd27000, 32'd25000, 32'd25000,
                                       32'd1000, 32'd3000000, 32'd0, 32'd25000, 32'hFFFF_FFF0, 32'd19200};
  localparam bit [31:0] V_COUT[NV] = '{32'd500000, 32'd333333, 32'd62500, 32'd123456, 32'd900000, 32'd900000,
                                       32'd400000, 32'd31200000, 32'd500000, 32'd0, 32'd500000, 32'd48000};
  localparam bit [31:0] V_LLO [NV] = '{32'd31250, 32'd31250, 32'd31250, 32'd31250, 32'd31250, 32'd31250,
                                       32'd31250, 32'd31250, 32'd31250, 32'd31250, 32'd31250, 32'd31250};
  localparam bit [31:0] V_LHI [NV] = '{32'd500000, 32'd500000, 32'd500000, 32'd500000, 32'd500000, 32'd500000,
                                       32'd500000, 32'd30000000, 32'd500000, 32'd500000, 32'd500000, 32'd500000};
  localparam bit        V_REV [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam int        V_CLS [NV] = '{0, 0, 0, 0, 1, 0, 1, 1, 2, 2, 2, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rev = 1'b0;
  logic [FW-1:0] cin = '0, cout = '0, llo = '0, lhi = '0;
  logic done, bad_input, no_fit;
  logic [2:0] idf;
  logic [6:0] ndiv;
  logic [3:0] odf;
  logic [FW-1:0] fout;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pll_div_search #(.FW(FW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rev_fast(rev),
    .clkin_khz(cin), .clkout_khz(cout), .lane_lo_kbps(llo), .lane_hi_kbps(lhi),
    .done(done), .bad_input(bad_input), .no_fit(no_fit),
    .idf(idf), .ndiv(ndiv), .odf(odf), .fout_khz(fout)
  );

  task automatic chk(input string rq, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // search restated from the requirements
  task automatic model(input int c_in, input int c_out, input longint l_lo, input longint l_hi,
                       input bit r, output longint e_i, output longint e_n, output longint e_o,
                       output longint e_f, output bit e_bad, output bit e_none);
    longint vlo, vhi, best, lo, hi, n, f, d, m;
    bit stop;
    e_i = 0; e_n = 0; e_o = 0; e_f = 0; e_bad = 0; e_none = 0;
    if (c_in <= 0 || c_out <= 0) begin
      e_bad = 1;
      return;
    end
    vlo = (r ? 2 * l_lo : l_lo) * 16;
    vhi = (r ? 2 * l_hi : l_hi) * 2;
    best = 1000000;
    stop = 0;
    for (int i = 1; i <= 7 && !stop; i++) begin
      lo = (vlo * i) / (2 * longint'(c_in)) + 1;
      hi = (vhi * i) / (2 * longint'(c_in));
      if (lo >= 125) break;
      if (lo < 10) lo = 10;
      if (hi > 125) hi = 125;
      for (int k = 0; k < 4 && !stop; k++) begin
        m = longint'(i) << k;
        n = (m * c_out + c_in / 2) / c_in;
        if (n < lo || n > hi) continue;
        f = (longint'(c_in) * n + m / 2) / m;
        d = (f > c_out) ? f - c_out : c_out - f;
        if (d < best) begin
          best = d; e_i = i; e_n = n; e_o = longint'(1) << k; e_f = f;
        end
        if (d == 0) stop = 1;
      end
    end
    e_none = (e_i == 0);
  endtask

  task automatic launch(input int v, output int lat);
    @(negedge clk);
    cin = V_CIN[v]; cout = V_COUT[v]; llo = V_LLO[v]; lhi = V_LHI[v]; rev = V_REV[v];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R11 watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint e_i, e_n, e_o, e_f, lo, hi, vlo, vhi;
    bit e_bad, e_none;
    int lat;

    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 done", done, 0);
    chk("R1 flags", {bad_input, no_fit}, 0);
    chk("R1 dividers", {idf, ndiv, odf}, 0);
    chk("R1 fout", fout, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      launch(v, lat);
      model(int'(V_CIN[v]), int'(V_COUT[v]), V_LLO[v], V_LHI[v], V_REV[v], e_i, e_n, e_o, e_f, e_bad, e_none);
      chk("R11 done seen", done, 1);
      chk("R4 idf", idf, e_i);
      chk("R4 ndiv", ndiv, e_n);
      chk("R4 odf", odf, e_o);
      chk("R4 fout", fout, e_f);
      chk("R8 bad flag", bad_input, e_bad);
      chk("R9 none flag", no_fit, e_none);
      chk("R4 class", {30'd0, bad_input, no_fit}, (V_CLS[v] == 2) ? 2 : (V_CLS[v] == 1) ? 1 : 0);
      if (!e_bad && !e_none) begin
        chk("R2 idf range", (idf >= 1 && idf <= 7), 1);
        chk("R2 ndiv range", (ndiv >= 10 && ndiv <= 125), 1);
        chk("R2 odf value", (odf == 1 || odf == 2 || odf == 4 || odf == 8), 1);
        if (idf != 0 && odf != 0)
          chk("R3 fout rounding", fout,
              (longint'(V_CIN[v]) * ndiv + (longint'(idf) * odf) / 2) / (longint'(idf) * odf));
        vlo = (V_REV[v] ? 2 * longint'(V_LLO[v]) : longint'(V_LLO[v])) * 16;
        vhi = (V_REV[v] ? 2 * longint'(V_LHI[v]) : longint'(V_LHI[v])) * 2;
        lo = (vlo * idf) / (2 * longint'(V_CIN[v])) + 1;
        hi = (vhi * idf) / (2 * longint'(V_CIN[v]));
        if (lo < 10) lo = 10;
        if (hi > 125) hi = 125;
        chk("R5 ndiv inside window", (ndiv >= lo && ndiv <= hi), 1);
      end
      if (e_bad || e_none)
        chk("R9 zero results", {idf, ndiv, odf, fout}, 0);
      if (v == 0) chk("R7 exact exit latency", lat <= 5 * RUN, 1);
      if (v == 4) chk("R10 no fit without revision", no_fit, 1);
      if (v == 5) chk("R10 fit with doubled limits", {idf, ndiv, odf}, {3'd1, 7'd36, 4'd1});
      if (v == 6) chk("R6 window break latency", lat <= 3 * RUN, 1);
      if (v == 7) chk("R12 large error rejected", no_fit, 1);
      if (v == 10) chk("R8 negative reference", bad_input, 1);
      @(negedge clk);
      chk("R11 done one cycle", done, 0);
    end

    // R11: start during a running search is ignored
    @(negedge clk);
    cin = V_CIN[1]; cout = V_COUT[1]; llo = V_LLO[1]; lhi = V_LHI[1]; rev = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    cin = V_CIN[0]; cout = V_COUT[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    model(int'(V_CIN[1]), int'(V_COUT[1]), V_LLO[1], V_LHI[1], 1'b0, e_i, e_n, e_o, e_f, e_bad, e_none);
    chk("R11 busy start ignored ndiv", ndiv, e_n);
    chk("R11 busy start ignored fout", fout, e_f);
    lat = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R11 no second done", lat, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule